// File: doc/BRIEF.md
# Latched-Input Parallel-to-Serial Shifter

This block turns a parallel word into a serial bit stream in two stages. A holding register captures the parallel input word when a capture strobe arrives. A shift chain sits behind it. The chain either copies the holding register in parallel or moves one bit along per shift strobe, taking a new bit in at its first stage. The last stage of the chain drives the serial output.

The whole block runs in a single clock domain. Each external clock event for the holding register and for the chain reaches the block as a single-cycle strobe. A level-sensitive mode select chooses between parallel loading and shifting. A functional active-low reset clears only the chain. A separate system reset puts both registers into a known state at start-up.

Top module: `latched_p2s`

## Requirements
- R1: On a cycle with `cap_stb` high, the holding register takes `par_in` at that edge, whatever the levels of `rst_n` and `mode_sel`.
- R2: On a cycle with `cap_stb` low, the holding register keeps its value. A low `rst_n` never changes it.
- R3: On a cycle with `sys_rst_n` high and `rst_n` low, every chain stage is 0 after the edge, and so `ser_out` is 0. This takes priority over parallel load and shifting.
- R4: On a cycle with `mode_sel` = 0 (load mode) and `rst_n` high, the chain copies the holding register at that edge. No shift strobe is needed.
- R5: On a load-mode cycle with `cap_stb` high and `rst_n` high, the chain takes the new `par_in` at the same edge as the holding register. `ser_out` then equals `par_in[WIDTH-1]`.
- R6: On a cycle with `mode_sel` = 1 (shift mode), `shf_stb` high and `rst_n` high, stage 0 takes `ser_in` and stage k takes the old stage k-1. The old value of stage WIDTH-1 is lost.
- R7: `ser_out` always equals chain stage WIDTH-1. `par_in[0]` maps to stage 0 and `par_in[WIDTH-1]` maps to stage WIDTH-1.
- R8: In shift mode, a capture strobe and a shift strobe in the same cycle both take effect, each on its own register.
- R9: In shift mode with no strobe and `rst_n` high, both registers hold their values.
- R10: While `sys_rst_n` is low, the holding register and the chain both clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| sys_rst_n | input | 1 | Synchronous active-low system reset; clears both registers |
| rst_n | input | 1 | Synchronous active-low functional reset; clears the chain only |
| cap_stb | input | 1 | Single-cycle strobe that captures `par_in` |
| shf_stb | input | 1 | Single-cycle strobe that shifts the chain in shift mode |
| mode_sel | input | 1 | 0 = load chain from holding register, 1 = shift mode |
| par_in | input | WIDTH | Parallel data word |
| ser_in | input | 1 | Serial data into chain stage 0 |
| ser_out | output | 1 | Serial output, chain stage WIDTH-1 |

## Verification
The assertions take every strobe to be one cycle wide and sampled at the clock edge. They also take `mode_sel` and `rst_n` to be plain levels that may change on any cycle. Nothing is assumed about how strobes are spaced, or about how they coincide with each other or with the resets. The stimulus drives every input one full half-period before the active edge. It then mixes directed phases with a long random run, where strobes, select changes and functional resets land in any combination and even on back-to-back cycles. Only the system reset is kept to the start of the run.

// File: rtl/latched_p2s_pkg.sv
// Shared types for the latched-input parallel-to-serial shifter.
package latched_p2s_pkg;

    // Level of the mode select input.
    typedef enum logic {
        SEL_LOAD  = 1'b0,
        SEL_SHIFT = 1'b1
    } p2s_mode_e;

endpackage

// File: rtl/p2s_hold_reg.sv
// Holding register in front of the shift chain.
// Captures the parallel word on a capture strobe and holds it otherwise.
// Only the system reset clears it; the functional reset never reaches it.
// Also presents the value it will hold after the current edge, so the
// chain can load new data in the same cycle as the capture.
// Assumes: cap_stb is a one-cycle pulse synchronous to clk.
module p2s_hold_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             sys_rst_n,
    input  logic             cap_stb,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] hold_q,
    output logic [WIDTH-1:0] hold_next
);

    // Value after this edge: the new word on a strobe, else the kept one.
    always_comb begin
        hold_next = cap_stb ? par_in : hold_q;
    end

    // State update: system reset clear, else take the next value.
    always_ff @(posedge clk) begin
        if (!sys_rst_n) begin
            hold_q <= '0;
        end else begin
            hold_next_q_unused_guard: begin
                hold_q <= hold_next;
            end
        end
    end

    assert_capture_takes_word_R1: assert property (@(posedge clk) disable iff (!sys_rst_n)
        cap_stb |=> hold_q == $past(par_in));

    assert_hold_without_strobe_R2: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !cap_stb |=> $stable(hold_q));

    assert_sysreset_clears_hold_R10: assert property (@(posedge clk)
        !sys_rst_n |=> hold_q == '0);

endmodule

// File: rtl/p2s_shift_chain.sv
// Shift chain of the parallel-to-serial converter.
// In load mode it copies the load value every cycle. In shift mode it moves
// one place toward the top stage per shift strobe, with ser_in entering
// stage 0. Either reset clears it, and reset wins over load and shift.
// Assumes: shf_stb is a one-cycle pulse; mode_sel is a plain level.
module p2s_shift_chain
    import latched_p2s_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             sys_rst_n,
    input  logic             rst_n,
    input  logic             shf_stb,
    input  p2s_mode_e        mode,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] stages
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] shifted;

    // Per-stage source for a shift: serial input at stage 0, else the stage below.
    for (genvar k = 0; k < WIDTH; k++) begin : g_stage
        if (k == 0) begin : g_first
            always_comb begin
                shifted[k] = ser_in;
            end
        end else begin : g_rest
            always_comb begin
                shifted[k] = stages[k-1];
            end
        end
    end

    // State update: reset first, then parallel load, then shift, else hold.
    always_ff @(posedge clk) begin
        if (!sys_rst_n || !rst_n) begin
            stages <= '0;
        end else if (mode == SEL_LOAD) begin
            stages <= load_val;
        end else if (shf_stb) begin
            stages <= shifted;
        end
    end

    assert_reset_clears_chain_R3: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !rst_n |=> stages == '0);

    assert_load_mode_copies_R4: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (rst_n && mode == SEL_LOAD) |=> stages == $past(load_val));

    assert_shift_entry_bit_R6: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (rst_n && mode == SEL_SHIFT && shf_stb) |=> stages[0] == $past(ser_in));

    assert_shift_top_moves_R6: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (rst_n && mode == SEL_SHIFT && shf_stb) |=> stages[TOP] == $past(stages[TOP-1]));

    assert_idle_chain_holds_R9: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (rst_n && mode == SEL_SHIFT && !shf_stb) |=> $stable(stages));

    assert_sysreset_clears_chain_R10: assert property (@(posedge clk)
        !sys_rst_n |=> stages == '0);

endmodule

// File: rtl/latched_p2s.sv
// Top of the latched-input parallel-to-serial shifter.
// A holding register feeds a shift chain; the chain's top stage is the
// serial output. The chain loads from the holding register's next value,
// so a capture in load mode reaches the output at the same edge.
// Assumes: one clock domain; strobes are one cycle wide.
module latched_p2s
    import latched_p2s_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             sys_rst_n,
    input  logic             rst_n,
    input  logic             cap_stb,
    input  logic             shf_stb,
    input  logic             mode_sel,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic             ser_out
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] hold_q;
    logic [WIDTH-1:0] hold_next;
    logic [WIDTH-1:0] chain;
    p2s_mode_e        mode;

    // Decode the select level into the mode type.
    always_comb begin
        mode = mode_sel ? SEL_SHIFT : SEL_LOAD;
    end

    p2s_hold_reg #(.WIDTH(WIDTH)) u_hold (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .cap_stb   (cap_stb),
        .par_in    (par_in),
        .hold_q    (hold_q),
        .hold_next (hold_next)
    );

    p2s_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .rst_n     (rst_n),
        .shf_stb   (shf_stb),
        .mode      (mode),
        .ser_in    (ser_in),
        .load_val  (hold_next),
        .stages    (chain)
    );

    // Serial output is the top chain stage.
    always_comb begin
        ser_out = chain[TOP];
    end

    assert_load_capture_to_out_R5: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (rst_n && !mode_sel && cap_stb) |=> ser_out == $past(par_in[TOP]));

    assert_shift_and_capture_R8: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (rst_n && mode_sel && cap_stb && shf_stb) |=> (hold_q == $past(par_in)) && (chain[0] == $past(ser_in)));

    assert_hold_fixed_under_reset_R2: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (!rst_n && !cap_stb) |=> $stable(hold_q));

endmodule

// File: tb/tb_latched_p2s.sv
// Bench: behavioural model (a bit queue plus an integer word), compared every clock.
module tb_latched_p2s;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         sys_rst_n = 1'b0;
    logic         rst_n = 1'b1;
    logic         cap_stb = 1'b0;
    logic         shf_stb = 1'b0;
    logic         mode_sel = 1'b1;
    logic [W-1:0] par_in = '0;
    logic         ser_in = 1'b0;
    logic         ser_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Model state: queue index 0 is the stage fed by ser_in.
    int m_hold = 0;
    bit m_q[$];

    always #2.5 clk = ~clk;

    latched_p2s #(.WIDTH(W)) dut (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .rst_n     (rst_n),
        .cap_stb   (cap_stb),
        .shf_stb   (shf_stb),
        .mode_sel  (mode_sel),
        .par_in    (par_in),
        .ser_in    (ser_in),
        .ser_out   (ser_out)
    );

    task automatic model_clear();
        m_q.delete();
        for (int i = 0; i < W; i++) m_q.push_back(1'b0);
    endtask

    // Apply one clock of model behaviour from the inputs seen at the edge.
    task automatic model_edge();
        int nh;
        nh = cap_stb ? int'(par_in) : m_hold;
        if (!sys_rst_n) begin
            m_hold = 0;
            model_clear();
        end else begin
            m_hold = nh;
            if (!rst_n) begin
                model_clear();
            end else if (!mode_sel) begin
                for (int i = 0; i < W; i++) m_q[i] = nh[i];
            end else if (shf_stb) begin
                m_q.push_front(ser_in);
                void'(m_q.pop_back());
            end
        end
    endtask

    task automatic check(input string tag);
        checks++;
        if (ser_out !== m_q[W-1]) begin
            failures++;
            $display("FAIL %s ser_out actual=%0b expected=%0b at %0t", tag, ser_out, m_q[W-1], $time);
        end
    endtask

    // Drive inputs at the falling edge, model at the rising edge, compare at the next fall.
    task automatic step(input bit cap, input bit shf, input bit sel, input bit rst,
                        input bit sin, input logic [W-1:0] par, input string tag);
        cap_stb = cap; shf_stb = shf; mode_sel = sel; rst_n = rst;
        ser_in = sin; par_in = par;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] pat;
        model_clear();
        @(negedge clk);
        sys_rst_n = 1'b0;
        step(1, 1, 0, 1, 1, 8'hFF, "R10");
        step(0, 0, 1, 1, 0, 8'h00, "R10");
        sys_rst_n = 1'b1;
        step(0, 0, 1, 1, 0, 8'h00, "R10 reset state");

        // Load-mode capture reaches output at once.
        step(1, 0, 0, 1, 0, 8'hA5, "R5");
        // Shift the word out, feeding a pattern in.
        pat = 8'b0110_1001;
        for (int i = 0; i < W; i++) step(0, 1, 1, 1, pat[i], 8'h00, "R6 R7");
        for (int i = 0; i < W; i++) step(0, 1, 1, 1, 1'b0, 8'h00, "R6 R7 fed bits");
        // Idle holds.
        step(1, 0, 0, 1, 0, 8'h81, "R5");
        for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 1, 8'h00, "R9");
        // Capture in shift mode leaves chain, then load mode exposes it.
        step(1, 0, 1, 1, 0, 8'h3C, "R1 R9");
        step(0, 0, 0, 1, 0, 8'hFF, "R1 R4");
        for (int i = 0; i < W; i++) step(0, 1, 1, 1, 0, 8'h00, "R4 R6");
        // Functional reset with capture in load mode.
        step(1, 0, 1, 1, 0, 8'h80, "R1");
        step(0, 0, 0, 1, 0, 8'h00, "R4");
        step(1, 0, 0, 0, 0, 8'hC3, "R3 R1");
        step(0, 1, 1, 0, 1, 8'h00, "R3");
        step(0, 0, 0, 1, 0, 8'h00, "R2 R4");
        for (int i = 0; i < W; i++) step(0, 1, 1, 1, 0, 8'h00, "R2 R6");
        // Reset in shift mode keeps the held word.
        step(1, 0, 0, 1, 0, 8'h5A, "R5");
        step(0, 0, 1, 0, 0, 8'h00, "R3");
        step(0, 0, 1, 0, 0, 8'h00, "R3");
        step(0, 0, 0, 1, 0, 8'h00, "R2 R4");
        for (int i = 0; i < W; i++) step(0, 1, 1, 1, 1, 8'h00, "R2 R6");
        // Capture and shift in the same cycle.
        step(1, 0, 0, 1, 0, 8'hF0, "R5");
        step(1, 1, 1, 1, 1, 8'h0F, "R8");
        step(0, 1, 1, 1, 0, 8'h00, "R8 R6");
        step(0, 0, 0, 1, 0, 8'h00, "R8 R4");
        for (int i = 0; i < W; i++) step(0, 1, 1, 1, 0, 8'h00, "R8 R6");
        // Random mix.
        for (int i = 0; i < 4000; i++) begin
            step(1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 4) != 0), 1'($urandom_range(0, 12) != 0),
                 1'($urandom_range(0, 1)), W'($urandom), "R7 random");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule